// File: doc/BRIEF.md
# Register-Amount Shifter with Carry Output

This block is a 32-bit combinational shifter for operations whose shift count is held in a register rather than encoded as a constant. It applies one of four operations to a data word: logical left, logical right, arithmetic right or rotate right. Alongside the shifted word it produces a carry bit and a flag saying whether that carry is a newly computed value.

The count is taken from the least significant byte of a 32-bit count word, so counts from 0 to 255 are possible. The block gives exact results for every count in that range: a count of zero, counts inside the word, a count equal to the word width, and counts beyond it. Rotates reduce the count modulo 32. When the count is zero, the incoming carry is passed straight to the carry output and the update flag stays low. A flag-setting datapath can therefore use `carry_out` directly, whatever the count was.

Top module: `reg_shift_carry`

## Requirements
- R1: Only bits [7:0] of `sh_word` set the count; bits [31:8] have no effect on any output.
- R2: With a count of zero, `result` equals `op_a`, `carry_out` equals `carry_in` and `carry_upd` is 0, for every `sh_kind`.
- R3: `sh_kind` = 2'b00 (logical left). For a count n from 1 to 31, `result` = `op_a` << n and `carry_out` = `op_a`[32−n]. For n = 32, `result` = 0 and `carry_out` = `op_a`[0].
- R4: `sh_kind` = 2'b01 (logical right). For a count n from 1 to 31, `result` = `op_a` >> n and `carry_out` = `op_a`[n−1]. For n = 32, `result` = 0 and `carry_out` = `op_a`[31].
- R5: For logical left or logical right with a count above 32, `result` = 0 and `carry_out` = 0.
- R6: `sh_kind` = 2'b10 (arithmetic right). For a count n from 1 to 31, `result` is `op_a` shifted right by n with sign fill, and `carry_out` = `op_a`[n−1]. For a count of 32 or more, every bit of `result` equals `op_a`[31], and so does `carry_out`.
- R7: `sh_kind` = 2'b11 (rotate right) uses m = count mod 32. For m ≠ 0, `result` is `op_a` rotated right by m and `carry_out` = `op_a`[m−1]. For m = 0 with a non-zero count, `result` = `op_a` and `carry_out` = `op_a`[31].
- R8: `carry_upd` is 1 exactly when the count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | Data word to shift |
| sh_word | input | 32 | Count word; only the low byte is used |
| sh_kind | input | 2 | Operation: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_in | input | 1 | Current carry, passed through when the count is zero |
| result | output | 32 | Shifted data word |
| carry_out | output | 1 | Computed carry, or `carry_in` when the count is zero |
| carry_upd | output | 1 | High when `carry_out` is a newly computed carry |

## Verification
Two decisions can apply to the same input at once: reducing a rotate count modulo 32, and the carry pass-through for a zero count. They meet whenever the low byte of the count is a non-zero multiple of 32 (32, 64, 96, 128, 160, 192, 224). There the rotate must return the data unchanged, as a zero count would, but it must still load bit 31 into the carry and raise the update flag. The bench applies rotates with each of these counts, with both carry-in values, against a count of exactly zero. It judges the carry and update outputs by comparing every cycle with a behavioural model. It also drives count words whose upper bits are set over a low byte of zero, so that an implementation that reads too many count bits is caught.

// File: rtl/reg_shift_pkg.sv
// Package: shared types for the register-amount shifter.
// Assumes the two-bit operation select is encoded as listed below.
package reg_shift_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/shift_amount_decode.sv
// Sorts the count byte into classes: zero, inside the word, exactly the
// word width, beyond it, and a non-zero multiple of the width (rotate case).
// Assumes DATA_W is a power of two and fits in AMT_W bits.
module shift_amount_decode #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [AMT_W-1:0]          amt,
    output logic                      is_zero,
    output logic                      in_range,
    output logic                      is_exact,
    output logic                      is_over,
    output logic                      rot_whole,
    output logic [$clog2(DATA_W)-1:0] amt_low
);
    localparam int STAGE_N = $clog2(DATA_W);
    localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

    // Classify the count against the word width.
    always_comb begin
        amt_low   = amt[STAGE_N-1:0];
        is_zero   = (amt == '0);
        in_range  = !is_zero && (amt < WIDTH_AMT);
        is_exact  = (amt == WIDTH_AMT);
        is_over   = (amt > WIDTH_AMT);
        rot_whole = !is_zero && (amt_low == '0);
    end
endmodule

// File: rtl/shift_barrel_core.sv
// Logarithmic right shifter/rotator: one stage per count bit.
// In shift mode the vacated bits take the fill value; in rotate mode
// they take the bits shifted out. Assumes DATA_W is a power of two.
module shift_barrel_core #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         din,
    input  logic [$clog2(DATA_W)-1:0] amt,
    input  logic                      rotate,
    input  logic                      fill,
    output logic [DATA_W-1:0]         dout
);
    localparam int STAGE_N = $clog2(DATA_W);

    logic [DATA_W-1:0] stg [0:STAGE_N];

    assign stg[0] = din;

    // Each stage moves the word by a power of two when its count bit is set.
    for (genvar s = 0; s < STAGE_N; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stg[s+1] = !amt[s] ? stg[s] :
                          rotate  ? {stg[s][SH-1:0], stg[s][DATA_W-1:SH]} :
                                    {{SH{fill}}, stg[s][DATA_W-1:SH]};
    end

    assign dout = stg[STAGE_N];
endmodule

// File: rtl/shift_carry_pick.sv
// Selects the last bit shifted out of a right shift by amt (bit amt-1).
// Assumes amt is non-zero when the output is used.
module shift_carry_pick #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         src,
    input  logic [$clog2(DATA_W)-1:0] amt,
    output logic                      bit_out
);
    localparam int STAGE_N = $clog2(DATA_W);

    logic [STAGE_N-1:0] idx;

    // Index of the last bit that leaves the word.
    always_comb begin
        idx     = amt - 1'b1;
        bit_out = src[idx];
    end
endmodule

// File: rtl/reg_shift_carry.sv
// Top: register-amount shifter with carry output.
// Left shifts are made by reversing the bit order, shifting right and
// reversing back, so one right-only core serves all four operations.
// Purely combinational; no clock or reset.
module reg_shift_carry #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] sh_word,
    input  logic [1:0]        sh_kind,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              carry_upd
);
    import reg_shift_pkg::*;

    localparam int STAGE_N = $clog2(DATA_W);

    shift_kind_e        kind;
    logic [DATA_W-1:0]  a_rev, src, core_out, core_rev, sign_word;
    logic               is_zero, in_range, is_exact, is_over, rot_whole;
    logic [STAGE_N-1:0] amt_low;
    logic               pick_bit;
    logic               unused_hi;

    assign kind      = shift_kind_e'(sh_kind);
    assign unused_hi = ^sh_word[DATA_W-1:AMT_W];
    assign sign_word = {DATA_W{op_a[DATA_W-1]}};

    // Bit-order reversal of the input and of the core output.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign a_rev[i]    = op_a[DATA_W-1-i];
        assign core_rev[i] = core_out[DATA_W-1-i];
    end

    assign src = (kind == SK_LSL) ? a_rev : op_a;

    shift_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
        .amt       (sh_word[AMT_W-1:0]),
        .is_zero   (is_zero),
        .in_range  (in_range),
        .is_exact  (is_exact),
        .is_over   (is_over),
        .rot_whole (rot_whole),
        .amt_low   (amt_low)
    );

    shift_barrel_core #(.DATA_W(DATA_W)) u_core (
        .din    (src),
        .amt    (amt_low),
        .rotate (kind == SK_ROR),
        .fill   ((kind == SK_ASR) & op_a[DATA_W-1]),
        .dout   (core_out)
    );

    shift_carry_pick #(.DATA_W(DATA_W)) u_pick (
        .src     (src),
        .amt     (amt_low),
        .bit_out (pick_bit)
    );

    // Pick result and carry by operation and count class.
    always_comb begin
        result    = op_a;
        carry_out = carry_in;
        carry_upd = !is_zero;
        if (is_zero) begin
            result    = op_a;
            carry_out = carry_in;
        end else if (kind == SK_ROR) begin
            result    = core_out;
            carry_out = rot_whole ? op_a[DATA_W-1] : pick_bit;
        end else if (in_range) begin
            result    = (kind == SK_LSL) ? core_rev : core_out;
            carry_out = pick_bit;
        end else if (kind == SK_ASR) begin
            result    = sign_word;
            carry_out = op_a[DATA_W-1];
        end else if (is_exact) begin
            result    = '0;
            carry_out = src[DATA_W-1];
        end else if (is_over) begin
            result    = '0;
            carry_out = 1'b0;
        end
    end
endmodule

// File: rtl/reg_shift_carry_chk.sv
// Checker for reg_shift_carry: immediate assertions on the port values,
// evaluated whenever an input or output changes.
module reg_shift_carry_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] sh_word,
    input logic [1:0]        sh_kind,
    input logic              carry_in,
    input logic [DATA_W-1:0] result,
    input logic              carry_out,
    input logic              carry_upd
);
    localparam int STAGE_N = $clog2(DATA_W);

    logic [AMT_W-1:0] amt;
    assign amt = sh_word[AMT_W-1:0];

    // Port-level rules that hold for any legal input.
    always_comb begin
        if (amt == '0) begin
            AST_ZERO_PASSTHRU: assert (result == op_a && carry_out == carry_in && !carry_upd); // R2
        end
        AST_UPD_ON_NONZERO: assert (carry_upd == (amt != '0)); // R8
        if (sh_kind[1] == 1'b0 && amt > AMT_W'(DATA_W)) begin
            AST_LOGICAL_OVER_CLEAR: assert (result == '0 && carry_out == 1'b0); // R5
        end
        if (sh_kind == 2'b10 && amt >= AMT_W'(DATA_W)) begin
            AST_ASR_SIGN_FILL: assert (result == {DATA_W{op_a[DATA_W-1]}} && carry_out == op_a[DATA_W-1]); // R6
        end
        if (sh_kind == 2'b11 && amt != '0 && amt[STAGE_N-1:0] == '0) begin
            AST_ROR_WHOLE_TURN: assert (result == op_a && carry_out == op_a[DATA_W-1]); // R7
        end
    end
endmodule

bind reg_shift_carry reg_shift_carry_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .op_a      (op_a),
    .sh_word   (sh_word),
    .sh_kind   (sh_kind),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .carry_upd (carry_upd)
);

// File: tb/tb_reg_shift_carry.sv
module tb_reg_shift_carry;

    typedef struct {
        logic [31:0] a;
        logic [31:0] w;
        logic [1:0]  k;
        logic        c;
    } vec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, sh_word = '0;
    logic [1:0]  sh_kind = 2'b00;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out, carry_upd;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;
    vec_t vq[$];

    always #2.5 clk = ~clk;

    reg_shift_carry dut (
        .op_a(op_a), .sh_word(sh_word), .sh_kind(sh_kind), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .carry_upd(carry_upd)
    );

    // Behavioural reference: returns {result, carry, update}.
    function automatic logic [33:0] model(vec_t v);
        int n;
        int m;
        logic [31:0] r;
        logic        cy;
        n = int'(v.w & 32'hFF);
        if (n == 0) return {v.a, v.c, 1'b0};
        case (v.k)
            2'b00: begin
                if (n < 32) begin r = v.a << n; cy = v.a[32-n]; end
                else if (n == 32) begin r = 0; cy = v.a[0]; end
                else begin r = 0; cy = 0; end
            end
            2'b01: begin
                if (n < 32) begin r = v.a >> n; cy = v.a[n-1]; end
                else if (n == 32) begin r = 0; cy = v.a[31]; end
                else begin r = 0; cy = 0; end
            end
            2'b10: begin
                if (n < 32) begin r = $unsigned($signed(v.a) >>> n); cy = v.a[n-1]; end
                else begin r = {32{v.a[31]}}; cy = v.a[31]; end
            end
            default: begin
                m = n % 32;
                if (m == 0) begin r = v.a; cy = v.a[31]; end
                else begin r = (v.a >> m) | (v.a << (32 - m)); cy = v.a[m-1]; end
            end
        endcase
        return {r, cy, 1'b1};
    endfunction

    function automatic string tag_of(vec_t v);
        int n;
        n = int'(v.w & 32'hFF);
        if (v.w[31:8] != 0) return "R1";
        if (n == 0) return "R2";
        if (v.k == 2'b11) return "R7";
        if (v.k == 2'b10) return "R6";
        if (n > 32) return "R5";
        return (v.k == 2'b00) ? "R3" : "R4";
    endfunction

    task automatic push(logic [31:0] a, logic [31:0] w, logic [1:0] k, logic c);
        vec_t v;
        v.a = a; v.w = w; v.k = k; v.c = c;
        vq.push_back(v);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // Reset-time state: zero inputs pass through (R2).
        repeat (3) @(posedge clk);
        @(negedge clk);
        compared++;
        if (result !== 32'h0 || carry_out !== 1'b0 || carry_upd !== 1'b0) begin
            mismatched++;
            $display("FAIL R2 reset: actual=%h/%b/%b expected=00000000/0/0", result, carry_out, carry_upd);
        end
        rst_n = 1'b1;

        // Directed vectors.
        for (int k = 0; k < 4; k++) begin
            push(32'hA5C3_0F81, 0, 2'(k), 1'b1);           // R2
            push(32'h5A3C_F07E, 0, 2'(k), 1'b0);           // R2
            push(32'h8000_0001, 1, 2'(k), 1'b0);
            push(32'h8000_0001, 31, 2'(k), 1'b1);
            push(32'h8000_0001, 32, 2'(k), 1'b0);
            push(32'h7FFF_FFFE, 32, 2'(k), 1'b1);
            push(32'hFFFF_FFFF, 33, 2'(k), 1'b1);          // R5 / R6
            push(32'h8123_4567, 255, 2'(k), 1'b1);
            push(32'h1234_5678, 32'hFFFF_FF00, 2'(k), 1'b1); // R1: low byte zero
            push(32'h1234_5678, 32'h0000_0104, 2'(k), 1'b0); // R1: count 4
            push(32'hF000_000F, 32'h8000_0021, 2'(k), 1'b0); // R1: count 33
        end
        // Rotate by multiples of 32 vs zero (R7, R2, R8).
        for (int j = 1; j < 8; j++) begin
            push(32'h8000_0000 | 32'(j), 32'(j * 32), 2'b11, 1'b0);
            push(32'h0000_0010 * 32'(j), 32'(j * 32), 2'b11, 1'b1);
            push(32'hC0DE_0000 | 32'(j), 32'(j * 32 + 1), 2'b11, 1'b0);
        end
        // Every count for every operation.
        for (int k = 0; k < 4; k++)
            for (int n = 0; n < 256; n++)
                push(32'h9E37_79B9 ^ 32'(n * 7919), 32'(n), 2'(k), n[0]);
        // Random vectors.
        for (int i = 0; i < 2000; i++)
            push($urandom, ($urandom % 3 == 0) ? $urandom : ($urandom % 70), 2'($urandom), 1'($urandom));

        while (vq.size() > 0) begin
            vec_t v;
            logic [33:0] exp;
            string t;
            v = vq.pop_front();
            @(posedge clk);
            #1;
            op_a = v.a; sh_word = v.w; sh_kind = v.k; carry_in = v.c;
            @(negedge clk);
            exp = model(v);
            t = tag_of(v);
            compared++;
            if (carry_upd !== exp[0]) begin
                mismatched++;
                $display("FAIL R8 a=%h w=%h k=%0d: actual upd=%b expected=%b", v.a, v.w, v.k, carry_upd, exp[0]);
            end else if (result !== exp[33:2] || carry_out !== exp[1]) begin
                mismatched++;
                $display("FAIL %s a=%h w=%h k=%0d c=%b: actual=%h/%b expected=%h/%b",
                         t, v.a, v.w, v.k, v.c, result, carry_out, exp[33:2], exp[1]);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule